// File: doc/BRIEF.md
# Utilization-Banded Interrupt Moderator

This block decides when one transmit or receive queue should request a completion interrupt. Each finished frame arrives as a one-cycle pulse. A link-utilization percentage arrives with a valid strobe once per measurement period. A one-cycle microsecond tick arrives as well.

The most recent utilization sample selects one of four bands. Three of them have a programmable upper bound, and the fourth takes everything above. Each band has its own frame-count threshold. When enough frames have accumulated for the current band, the block raises a utilization interrupt and clears its frame counter.

A separate interval timer raises its own interrupt request. By default it fires only if traffic was seen during the interval. It can instead run continuously, and with auto-cancel enabled a utilization interrupt restarts its interval. Configuration is loaded through a small write port. A status word reports sticky interrupt flags, the current band and the frame count.

Top module: `intr_moderator`

## Requirements
- R1: After reset both interrupt outputs are low, the status word is all zero, the block is disabled, the timer interval is 0 and every threshold is all ones.
- R2: Address 1 holds three 7-bit band bounds, at bits [6:0], [14:8] and [22:16], in band order. The band is the first of the three whose bound is greater than or equal to the last sampled utilization, and the fourth band otherwise. The band code (0 to 3) is shown in status bits [5:4].
- R3: Address 2 holds the thresholds of bands 0 and 1, at bits [15:0] and [31:16]. Address 3 holds those of bands 2 and 3 in the same layout. The utilization interrupt pulses for one cycle, in the cycle after the clock edge at which the frame count becomes non-zero and at least the selected band's threshold.
- R4: The frame count is shown in status bits [31:16]. It clears when a utilization interrupt fires, and a frame in that same cycle is not counted. The count holds at 65535 rather than wrapping.
- R5: Address 0 holds the enable in bit 0, auto-cancel in bit 1, continuous mode in bit 2 and the timer interval, in ticks, in bits [31:16]. A write to it restarts the interval. An expiry occurs on the N-th tick after a restart. The timer interrupt pulses in the cycle after that tick edge, but only if a frame completed during the interval.
- R6: With continuous mode set, the timer interrupt pulses at every expiry even when no frame completed.
- R7: With auto-cancel set, a utilization interrupt restarts the timer interval, and that restart takes priority over an expiry on the same edge.
- R8: An interval of 0 stops the timer, and no timer interrupt is raised.
- R9: With the enable bit clear, neither interrupt is raised, while the frame count keeps counting. Setting the enable bit with the count already at or over the threshold raises the utilization interrupt in the cycle after the write edge.
- R10: Status bit 0 (utilization) and bit 1 (timer) are set by the matching interrupt pulse. A write to address 4 clears each bit whose data bit is 1, and a set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register address |
| cfg_wdata_i | input | 32 | Configuration write data |
| frame_done_i | input | 1 | One-cycle pulse per completed frame |
| util_valid_i | input | 1 | Strobe that samples util_pct_i |
| util_pct_i | input | 7 | Link utilization percentage |
| tick_us_i | input | 1 | One-cycle microsecond tick |
| util_irq_o | output | 1 | Utilization interrupt request pulse |
| timer_irq_o | output | 1 | Timer interrupt request pulse |
| status_o | output | 32 | Sticky flags, current band and frame count |

## Verification
The assertions assume that the frame, tick and utilization strobes are synchronous single-cycle pulses with no unknown values after reset. They also assume that the configuration is changed only through the write port. The stimulus drives every strobe for exactly one cycle between falling edges, and it writes only the five defined addresses. Each scenario starts from a fresh reset, so the timer phase and the frame count are known exactly. Expected interrupt cycles are derived from the write edge and the tick and frame edges that follow it.

// File: rtl/im_pkg.sv
package im_pkg;
   localparam int NUM_BANDS  = 4;
   localparam int NUM_BOUNDS = NUM_BANDS - 1;
   localparam int ADDR_W     = 3;
   localparam int DATA_W     = 32;

   typedef enum logic [1:0] {
      BAND_0 = 2'd0,
      BAND_1 = 2'd1,
      BAND_2 = 2'd2,
      BAND_3 = 2'd3
   } band_e;

   localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
   localparam logic [ADDR_W-1:0] A_BOUNDS  = 3'd1;
   localparam logic [ADDR_W-1:0] A_THR_LO  = 3'd2;
   localparam logic [ADDR_W-1:0] A_THR_HI  = 3'd3;
   localparam logic [ADDR_W-1:0] A_STS_CLR = 3'd4;
endpackage

// File: rtl/im_cfg_regs.sv
module im_cfg_regs
   import im_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int TMR_W = 16,
   parameter int PCT_W = 7
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               we_i,
   input  logic [ADDR_W-1:0]                  addr_i,
   input  logic [DATA_W-1:0]                  wdata_i,
   output logic                               enable_o,
   output logic                               auto_cancel_o,
   output logic                               continuous_o,
   output logic [TMR_W-1:0]                   interval_o,
   output logic [NUM_BOUNDS-1:0][PCT_W-1:0]   bound_o,
   output logic [NUM_BANDS-1:0][CNT_W-1:0]    thr_o,
   output logic                               restart_o,
   output logic [1:0]                         sts_clr_o
);
   localparam int FIELD_W = DATA_W / 2;

   if (CNT_W > FIELD_W) begin : g_bad_cnt
      $error("CNT_W must fit a half data word");
   end
   if (TMR_W > FIELD_W) begin : g_bad_tmr
      $error("TMR_W must fit a half data word");
   end
   if (PCT_W > 8 || PCT_W < 7) begin : g_bad_pct
      $error("PCT_W must be 7 or 8");
   end

   logic wr_ctrl, wr_bounds, wr_lo, wr_hi;
   assign wr_ctrl   = we_i && (addr_i == A_CTRL);
   assign wr_bounds = we_i && (addr_i == A_BOUNDS);
   assign wr_lo     = we_i && (addr_i == A_THR_LO);
   assign wr_hi     = we_i && (addr_i == A_THR_HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_o      <= 1'b0;
         auto_cancel_o <= 1'b0;
         continuous_o  <= 1'b0;
         interval_o    <= '0;
      end else if (wr_ctrl) begin
         enable_o      <= wdata_i[0];
         auto_cancel_o <= wdata_i[1];
         continuous_o  <= wdata_i[2];
         interval_o    <= wdata_i[FIELD_W +: TMR_W];
      end
   end

   for (genvar b = 0; b < NUM_BOUNDS; b++) begin : g_bound
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         bound_o[b] <= '0;
         else if (wr_bounds) bound_o[b] <= wdata_i[8*b +: PCT_W];
      end
   end

   for (genvar t = 0; t < NUM_BANDS; t++) begin : g_thr
      localparam int HALF = t % 2;
      logic wr_this;
      assign wr_this = (t < 2) ? wr_lo : wr_hi;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       thr_o[t] <= '1;
         else if (wr_this) thr_o[t] <= wdata_i[HALF*FIELD_W +: CNT_W];
      end
   end

   assign restart_o = wr_ctrl;
   assign sts_clr_o = (we_i && (addr_i == A_STS_CLR)) ? wdata_i[1:0] : 2'b00;
endmodule

// File: rtl/im_band_sel.sv
module im_band_sel
   import im_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int PCT_W = 7
) (
   input  logic [PCT_W-1:0]                  util_i,
   input  logic [NUM_BOUNDS-1:0][PCT_W-1:0]  bound_i,
   input  logic [NUM_BANDS-1:0][CNT_W-1:0]   thr_i,
   output band_e                             band_o,
   output logic [CNT_W-1:0]                  thr_o
);
   logic [NUM_BOUNDS-1:0] hit;

   for (genvar i = 0; i < NUM_BOUNDS; i++) begin : g_cmp
      assign hit[i] = (util_i <= bound_i[i]);
   end

   always_comb begin
      band_o = BAND_3;
      for (int i = NUM_BOUNDS - 1; i >= 0; i--) begin
         if (hit[i]) band_o = band_e'(2'(i));
      end
   end

   assign thr_o = thr_i[band_o];
endmodule

// File: rtl/im_util_path.sv
module im_util_path #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable_i,
   input  logic             frame_i,
   input  logic [CNT_W-1:0] thr_i,
   output logic             fire_o,
   output logic             irq_o,
   output logic [CNT_W-1:0] count_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic             irq_q;

   assign fire_o = enable_i && (cnt_q != '0) && (cnt_q >= thr_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         irq_q <= 1'b0;
      end else begin
         irq_q <= fire_o;
         if (fire_o)                          cnt_q <= '0;
         else if (frame_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign irq_o   = irq_q;
   assign count_o = cnt_q;

   AST_UTIL_PULSE:   assert property (@(posedge clk) disable iff (!rst_n)
                        irq_q |=> !irq_q);                                  // R3
   AST_CNT_CLEARED:  assert property (@(posedge clk) disable iff (!rst_n)
                        irq_q |-> (cnt_q == '0));                           // R4
   AST_CNT_SAT:      assert property (@(posedge clk) disable iff (!rst_n)
                        (cnt_q == CNT_MAX && !fire_o) |=> (cnt_q == CNT_MAX)); // R4
   AST_UTIL_QUIET:   assert property (@(posedge clk) disable iff (!rst_n)
                        !enable_i |=> !irq_q);                              // R9
endmodule

// File: rtl/im_timer_path.sv
module im_timer_path #(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable_i,
   input  logic             continuous_i,
   input  logic             auto_cancel_i,
   input  logic [TMR_W-1:0] interval_i,
   input  logic             restart_i,
   input  logic             tick_i,
   input  logic             frame_i,
   input  logic             util_fire_i,
   output logic             irq_o
);
   logic [TMR_W-1:0] tcnt_q;
   logic [TMR_W:0]   tnext;
   logic             traffic_q, irq_q;
   logic             active, cancel, expire, fire;

   assign active = enable_i && (interval_i != '0);
   assign cancel = auto_cancel_i && util_fire_i;
   assign tnext  = {1'b0, tcnt_q} + {{TMR_W{1'b0}}, 1'b1};
   assign expire = active && tick_i && !restart_i && !cancel &&
                   (tnext >= {1'b0, interval_i});
   assign fire   = expire && (continuous_i || traffic_q || frame_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tcnt_q    <= '0;
         traffic_q <= 1'b0;
         irq_q     <= 1'b0;
      end else begin
         irq_q <= fire;
         if (!active || restart_i || cancel || expire) tcnt_q <= '0;
         else if (tick_i)                              tcnt_q <= tnext[TMR_W-1:0];
         if (!active || restart_i || cancel || expire) traffic_q <= 1'b0;
         else if (frame_i)                             traffic_q <= 1'b1;
      end
   end

   assign irq_o = irq_q;

   AST_TMR_OFF:        assert property (@(posedge clk) disable iff (!rst_n)
                          (interval_i == '0 || !enable_i) |=> !irq_q);     // R8
   AST_TMR_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
                          !tick_i |=> !irq_q);                             // R5
   AST_TMR_CANCEL:     assert property (@(posedge clk) disable iff (!rst_n)
                          cancel |=> (tcnt_q == '0));                      // R7
   AST_TMR_GATED:      assert property (@(posedge clk) disable iff (!rst_n)
                          (!continuous_i && !traffic_q && !frame_i) |=> !irq_q); // R5
endmodule

// File: rtl/intr_moderator.sv
module intr_moderator
   import im_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int TMR_W = 16,
   parameter int PCT_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we_i,
   input  logic [2:0]        cfg_addr_i,
   input  logic [31:0]       cfg_wdata_i,
   input  logic              frame_done_i,
   input  logic              util_valid_i,
   input  logic [PCT_W-1:0]  util_pct_i,
   input  logic              tick_us_i,
   output logic              util_irq_o,
   output logic              timer_irq_o,
   output logic [31:0]       status_o
);
   localparam int CNT_LSB = DATA_W / 2;

   logic                              enable, auto_cancel, continuous, restart;
   logic [TMR_W-1:0]                  interval;
   logic [NUM_BOUNDS-1:0][PCT_W-1:0]  bound;
   logic [NUM_BANDS-1:0][CNT_W-1:0]   thr;
   logic [1:0]                        sts_clr;
   logic [PCT_W-1:0]                  util_q;
   band_e                             band;
   logic [CNT_W-1:0]                  thr_sel, count;
   logic                              util_fire;
   logic [1:0]                        sticky_q;

   im_cfg_regs #(.CNT_W(CNT_W), .TMR_W(TMR_W), .PCT_W(PCT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
      .wdata_i(cfg_wdata_i), .enable_o(enable), .auto_cancel_o(auto_cancel),
      .continuous_o(continuous), .interval_o(interval), .bound_o(bound),
      .thr_o(thr), .restart_o(restart), .sts_clr_o(sts_clr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            util_q <= '0;
      else if (util_valid_i) util_q <= util_pct_i;
   end

   im_band_sel #(.CNT_W(CNT_W), .PCT_W(PCT_W)) u_band (
      .util_i(util_q), .bound_i(bound), .thr_i(thr),
      .band_o(band), .thr_o(thr_sel)
   );

   im_util_path #(.CNT_W(CNT_W)) u_util (
      .clk(clk), .rst_n(rst_n), .enable_i(enable), .frame_i(frame_done_i),
      .thr_i(thr_sel), .fire_o(util_fire), .irq_o(util_irq_o), .count_o(count)
   );

   im_timer_path #(.TMR_W(TMR_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .enable_i(enable), .continuous_i(continuous),
      .auto_cancel_i(auto_cancel), .interval_i(interval), .restart_i(restart),
      .tick_i(tick_us_i), .frame_i(frame_done_i), .util_fire_i(util_fire),
      .irq_o(timer_irq_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sticky_q <= 2'b00;
      else        sticky_q <= (sticky_q & ~sts_clr) | {timer_irq_o, util_irq_o};
   end

   always_comb begin
      status_o                    = '0;
      status_o[1:0]               = sticky_q;
      status_o[5:4]               = band;
      status_o[CNT_LSB +: CNT_W]  = count;
   end

   AST_STICKY_UTIL:  assert property (@(posedge clk) disable iff (!rst_n)
                        util_irq_o |=> sticky_q[0]);                        // R10
   AST_STICKY_TMR:   assert property (@(posedge clk) disable iff (!rst_n)
                        timer_irq_o |=> sticky_q[1]);                       // R10
   AST_BAND_TOP:     assert property (@(posedge clk) disable iff (!rst_n)
                        (band == BAND_3) |-> (util_q > bound[0] && util_q > bound[1]
                                              && util_q > bound[2]));      // R2
   AST_BAND_FIRST:   assert property (@(posedge clk) disable iff (!rst_n)
                        (util_q <= bound[0]) |-> (band == BAND_0));         // R2
endmodule

// File: tb/intr_moderator_tb.sv
module intr_moderator_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we_i = 1'b0;
   logic [2:0]  cfg_addr_i = '0;
   logic [31:0] cfg_wdata_i = '0;
   logic        frame_done_i = 1'b0;
   logic        util_valid_i = 1'b0;
   logic [6:0]  util_pct_i = '0;
   logic        tick_us_i = 1'b0;
   logic        util_irq_o, timer_irq_o;
   logic [31:0] status_o;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   bit done     = 1'b0;

   typedef struct { int at; int kind; string req; } exp_t;
   exp_t exp_q[$];

   intr_moderator u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
      .cfg_wdata_i(cfg_wdata_i), .frame_done_i(frame_done_i),
      .util_valid_i(util_valid_i), .util_pct_i(util_pct_i),
      .tick_us_i(tick_us_i), .util_irq_o(util_irq_o),
      .timer_irq_o(timer_irq_o), .status_o(status_o)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(bit ok, string req, int act, int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   task automatic push(int at, int kind, string req);
      exp_t e;
      e.at = at; e.kind = kind; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic match(int kind);
      int idx = -1;
      for (int i = 0; i < exp_q.size(); i++)
         if (idx < 0 && exp_q[i].at == cyc && exp_q[i].kind == kind) idx = i;
      if (idx >= 0) begin
         chk(1'b1, exp_q[idx].req, kind, kind);
         exp_q.delete(idx);
      end else begin
         chk(1'b0, (kind == 0) ? "R3 unexpected util irq" : "R5 unexpected timer irq", 1, 0);
      end
   endtask

   // monitor: pops expected pulses as the design produces them
   always @(negedge clk) begin
      if (rst_n) begin
         while (exp_q.size() > 0 && exp_q[0].at < cyc) begin
            chk(1'b0, {exp_q[0].req, " missed pulse"}, 0, 1);
            void'(exp_q.pop_front());
         end
         if (util_irq_o)  match(0);
         if (timer_irq_o) match(1);
      end
   end

   task automatic step(bit f, bit t);
      frame_done_i = f; tick_us_i = t;
      @(negedge clk);
      frame_done_i = 1'b0; tick_us_i = 1'b0;
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d, output int edge_no);
      edge_no = cyc + 1;
      cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
      @(negedge clk);
      cfg_we_i = 1'b0;
   endtask

   task automatic set_util(logic [6:0] p);
      util_pct_i = p; util_valid_i = 1'b1;
      @(negedge clk);
      util_valid_i = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   function automatic logic [31:0] ctrl(bit en, bit ac, bit cont, int iv);
      return (32'(iv) << 16) | {29'd0, cont, ac, en};
   endfunction

   // bounds 20/50/80, thresholds 3/5/7/9 unless overridden
   task automatic base_cfg(int thr0);
      int e;
      wr(3'd1, (32'd80 << 16) | (32'd50 << 8) | 32'd20, e);
      wr(3'd2, (32'd5 << 16) | 32'(thr0), e);
      wr(3'd3, (32'd9 << 16) | 32'd7, e);
   endtask

   task automatic burst(int n, string req);
      for (int i = 0; i < n - 1; i++) step(1'b1, 1'b0);
      push(cyc + 2, 0, req);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
   endtask

   initial begin
      int e, c0;
      do_reset();
      chk(status_o == 32'd0, "R1 status after reset", int'(status_o), 0);
      chk(!util_irq_o && !timer_irq_o, "R1 irqs after reset", int'({util_irq_o, timer_irq_o}), 0);

      // band selection and utilization thresholds
      base_cfg(3);
      wr(3'd0, ctrl(1, 0, 0, 0), e);
      set_util(7'd10);
      chk(status_o[5:4] == 2'd0, "R2 band for 10%", int'(status_o[5:4]), 0);
      step(1'b1, 1'b0); step(1'b1, 1'b0);
      push(cyc + 2, 0, "R3 band0 threshold 3");
      step(1'b1, 1'b0);
      step(1'b1, 1'b0);                       // frame during fire cycle: dropped
      step(1'b0, 1'b0);
      chk(status_o[31:16] == 16'd0, "R4 clear wins over increment", int'(status_o[31:16]), 0);
      chk(status_o[0] == 1'b1, "R10 util sticky set", int'(status_o[0]), 1);
      wr(3'd4, 32'd1, e);
      step(1'b0, 1'b0);
      chk(status_o[0] == 1'b0, "R10 util sticky cleared", int'(status_o[0]), 0);

      set_util(7'd60);
      chk(status_o[5:4] == 2'd2, "R2 band for 60%", int'(status_o[5:4]), 2);
      for (int i = 0; i < 6; i++) step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      chk(status_o[31:16] == 16'd6, "R3 below threshold holds count", int'(status_o[31:16]), 6);
      push(cyc + 2, 0, "R3 band2 threshold 7");
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);

      set_util(7'd50);
      chk(status_o[5:4] == 2'd1, "R2 bound is inclusive", int'(status_o[5:4]), 1);
      burst(5, "R3 band1 threshold 5");

      set_util(7'd95);
      chk(status_o[5:4] == 2'd3, "R2 top band", int'(status_o[5:4]), 3);
      burst(9, "R3 band3 threshold 9");
      set_util(7'd81);
      chk(status_o[5:4] == 2'd3, "R2 just above last bound", int'(status_o[5:4]), 3);

      // traffic-gated timer
      do_reset();
      base_cfg(3);
      set_util(7'd10);
      wr(3'd0, ctrl(1, 0, 0, 4), c0);
      push(c0 + 8, 1, "R5 expiry with traffic");
      for (int j = 1; j <= 13; j++) step(j == 6, 1'b1);
      chk(status_o[1] == 1'b1, "R10 timer sticky set", int'(status_o[1]), 1);

      // continuous mode
      do_reset();
      base_cfg(3);
      wr(3'd0, ctrl(1, 0, 1, 4), c0);
      push(c0 + 4, 1, "R6 continuous 1");
      push(c0 + 8, 1, "R6 continuous 2");
      push(c0 + 12, 1, "R6 continuous 3");
      for (int j = 1; j <= 13; j++) step(1'b0, 1'b1);

      // auto-cancel
      do_reset();
      base_cfg(2);
      set_util(7'd10);
      wr(3'd0, ctrl(1, 1, 1, 4), c0);
      push(c0 + 4, 0, "R7 util fires");
      push(c0 + 8, 1, "R7 restarted interval 1");
      push(c0 + 12, 1, "R7 restarted interval 2");
      for (int j = 1; j <= 13; j++) step(j == 2 || j == 3, 1'b1);

      // interval zero
      do_reset();
      base_cfg(3);
      wr(3'd0, ctrl(1, 0, 1, 0), c0);
      for (int j = 1; j <= 12; j++) step(1'b0, 1'b1);
      chk(status_o[1] == 1'b0, "R8 no timer with interval 0", int'(status_o[1]), 0);

      // disabled: counts continue, saturate, then enable
      do_reset();
      base_cfg(3);
      set_util(7'd10);
      wr(3'd0, ctrl(0, 0, 1, 4), c0);
      for (int j = 0; j < 65540; j++) step(1'b1, 1'b1);
      step(1'b0, 1'b0);
      chk(status_o[31:16] == 16'hFFFF, "R4 saturation", int'(status_o[31:16]), 65535);
      chk(status_o[1:0] == 2'b00, "R9 disabled raises nothing", int'(status_o[1:0]), 0);
      push(cyc + 2, 0, "R9 enable with pending count");
      wr(3'd0, ctrl(1, 0, 0, 0), e);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      chk(status_o[31:16] == 16'd0, "R4 cleared after enable fire", int'(status_o[31:16]), 0);

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R3 all expected pulses seen", exp_q.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog all requirements actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule